// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit

This unit is the multiply lane of a 64-bit processor's execute stage. Each cycle it can take one operation: two 65-bit operands, an operation select, a 5-bit destination register number and a record flag. The issue stage has already widened both operands to 65 bits. It prepends a zero for an unsigned form or copies the sign bit for a signed form. With operands in that form, one signed 65x65 multiplier covers every signed and unsigned variant. The unit returns one writeback record a fixed number of cycles later. The record holds the 64-bit result, the unchanged register number and a register write enable. When the record flag is set, it also carries a 32-bit condition value with its own write enable.

The issue side uses only a valid qualifier, and the writeback side presents a valid qualifier with each result. There is no ready and no back-pressure. An operation is accepted on every clock edge where `in_valid` is high, and the consumer must take every result in the cycle it is presented. Pipeline depth is a parameter, default 4. A synchronous reset discards all work in flight.

Top module: `mul_unit`

## Requirements
- R1: An operation accepted on a rising edge with `in_valid` high is presented with `out_valid` high after exactly DEPTH rising edges, counting the accepting edge as the first. `out_valid` stays low in the cycles between, unless another operation is due.
- R2: If no operation was accepted DEPTH edges earlier, `out_valid` is low. This applies during idle periods and in gaps between operations.
- R3: Operation code 0 (and the unused code 3) returns bits 63:0 of the signed product of the two 65-bit operands. Example: 0x1000 times 0x1111 gives 0x0000000001111000.
- R4: Operation code 1 returns bits 127:64 of the product. This yields the unsigned high doubleword for zero-prefixed operands and the signed high doubleword for sign-prefixed operands.
- R5: Operation code 2 takes bits 63:32 of the product of two 32-bit values widened to 65 bits, by sign or by zeros. It places them in result bits 31:0 and repeats them in bits 63:32.
- R6: `out_dst` equals the destination number given with the operation, and `out_reg_we` equals `out_valid` in every cycle.
- R7: When the record flag was 0, `out_cond_we` is 0 and `out_cond` is 0.
- R8: When the record flag was 1, `out_cond_we` is 1 alongside `out_valid`. `out_cond` bits 27:0 are 0. Bits 31:28 are 1000 if the 64-bit result is negative (bit 63 set), 0010 if it is zero, and 0100 otherwise. A small positive result therefore gives 0x40000000.
- R9: Operations accepted on consecutive edges each produce exactly one result, in acceptance order, on consecutive cycles.
- R10: While `rst` is high on a rising edge, every pipeline valid bit is cleared. Operations in flight are never presented, and `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | 0 low doubleword, 1 high doubleword, 2 high word, 3 as 0 |
| in_dst | input | 5 | Destination register number |
| in_rec | input | 1 | Request a condition-value update |
| in_a | input | 65 | First operand, pre-widened |
| in_b | input | 65 | Second operand, pre-widened |
| out_valid | output | 1 | Writeback record valid |
| out_reg_we | output | 1 | Register write enable |
| out_dst | output | 5 | Destination register number |
| out_data | output | 64 | Result |
| out_cond_we | output | 1 | Condition value write enable |
| out_cond | output | 32 | Condition value |

## Verification
The bench builds the unit with its defaults: DEPTH of 4, a 64-bit result and 5-bit register numbers. With these values the cycle-exact latency and the idle gaps can be checked against a four-cycle window. The known worked example can also be replayed. Random runs cover each widening form: unsigned and signed doubleword, sign-extended word, zero- and sign-extended high word, and a sign-extended 16-bit immediate. These runs mix back-to-back issue with gaps. Directed cases reach the sign and zero corners of the condition code and a reset that arrives with work still in the pipeline.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    MOP_LO64 = 2'd0,
    MOP_HI64 = 2'd1,
    MOP_HI32 = 2'd2,
    MOP_RSVD = 2'd3
  } mop_e;

  localparam logic [3:0] CND_NEG  = 4'b1000;
  localparam logic [3:0] CND_POS  = 4'b0100;
  localparam logic [3:0] CND_ZERO = 4'b0010;
endpackage

// File: rtl/mul_array.sv
module mul_array #(
  parameter int OPW = 65,
  parameter int PW  = 128
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [PW-1:0]  p
);
  // Size both operands up to the kept product width first. The low PW bits
  // of the signed product then come out exactly.
  logic signed [PW-1:0] a_w;
  logic signed [PW-1:0] b_w;

  assign a_w = PW'($signed(a));
  assign b_w = PW'($signed(b));
  assign p   = a_w * b_w;
endmodule

// File: rtl/mul_pipe.sv
module mul_pipe #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  generate
    if (N == 0) begin : g_thru
      assign vld_o = vld_i;
      assign dat_o = dat_i;
    end else begin : g_regs
      logic [N-1:0] v;
      logic [W-1:0] d [N];
      for (genvar i = 0; i < N; i++) begin : g_st
        if (i == 0) begin : g_head
          always_ff @(posedge clk) begin
            if (rst) v[0] <= 1'b0;
            else     v[0] <= vld_i;
            if (vld_i) d[0] <= dat_i;
          end
        end else begin : g_tail
          always_ff @(posedge clk) begin
            if (rst) v[i] <= 1'b0;
            else     v[i] <= v[i-1];
            if (v[i-1]) d[i] <= d[i-1];
          end
        end
      end
      assign vld_o = v[N-1];
      assign dat_o = d[N-1];
    end
  endgenerate
endmodule

// File: rtl/mul_fmt.sv
module mul_fmt
  import mul_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CONDW = 32
) (
  input  logic [1:0]        op,
  input  logic [2*XLEN-1:0] prod,
  output logic [XLEN-1:0]   res,
  output logic [CONDW-1:0]  cond
);
  localparam int HW = XLEN / 2;

  logic [3:0] nib;

  always_comb begin
    case (mop_e'(op))
      MOP_HI64: res = prod[2*XLEN-1:XLEN];
      MOP_HI32: res = {2{prod[XLEN-1:HW]}};
      default:  res = prod[XLEN-1:0];
    endcase
  end

  always_comb begin
    if (res[XLEN-1])    nib = CND_NEG;
    else if (res == '0) nib = CND_ZERO;
    else                nib = CND_POS;
    cond = {nib, {(CONDW-4){1'b0}}};
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  parameter int DEPTH = 4,
  parameter int CONDW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [REGW-1:0]  in_dst,
  input  logic             in_rec,
  input  logic [XLEN:0]    in_a,
  input  logic [XLEN:0]    in_b,
  output logic             out_valid,
  output logic             out_reg_we,
  output logic [REGW-1:0]  out_dst,
  output logic [XLEN-1:0]  out_data,
  output logic             out_cond_we,
  output logic [CONDW-1:0] out_cond
);
  localparam int OPW  = XLEN + 1;
  localparam int PW   = 2 * XLEN;
  localparam int MW   = 2 + REGW + 1;
  localparam int MIDN = DEPTH - 2;

  // Stage 0 registers the issued operation.
  logic            s0_v;
  logic [1:0]      s0_op;
  logic [REGW-1:0] s0_dst;
  logic            s0_rec;
  logic [OPW-1:0]  s0_a;
  logic [OPW-1:0]  s0_b;

  always_ff @(posedge clk) begin
    if (rst) s0_v <= 1'b0;
    else     s0_v <= in_valid;
    if (in_valid) begin
      s0_op  <= in_op;
      s0_dst <= in_dst;
      s0_rec <= in_rec;
      s0_a   <= in_a;
      s0_b   <= in_b;
    end
  end

  logic [PW-1:0] prod;

  mul_array #(.OPW(OPW), .PW(PW)) u_arr (
    .a(s0_a),
    .b(s0_b),
    .p(prod)
  );

  // The middle stages carry the product and the control fields together.
  logic             m_v;
  logic [MW+PW-1:0] m_dat;

  mul_pipe #(.W(MW + PW), .N(MIDN)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .vld_i(s0_v),
    .dat_i({s0_op, s0_dst, s0_rec, prod}),
    .vld_o(m_v),
    .dat_o(m_dat)
  );

  logic [1:0]      m_op;
  logic [REGW-1:0] m_dst;
  logic            m_rec;
  logic [PW-1:0]   m_prod;

  assign {m_op, m_dst, m_rec, m_prod} = m_dat;

  logic [XLEN-1:0]  f_res;
  logic [CONDW-1:0] f_cond;

  mul_fmt #(.XLEN(XLEN), .CONDW(CONDW)) u_fmt (
    .op  (m_op),
    .prod(m_prod),
    .res (f_res),
    .cond(f_cond)
  );

  // The final stage registers the writeback record.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_cond_we <= 1'b0;
    end else begin
      out_valid   <= m_v;
      out_cond_we <= m_v & m_rec;
    end
    if (m_v) begin
      out_dst  <= m_dst;
      out_data <= f_res;
      out_cond <= m_rec ? f_cond : '0;
    end
  end

  assign out_reg_we = out_valid;
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
  parameter int XLEN  = 64,
  parameter int DEPTH = 4,
  parameter int CONDW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_reg_we,
  input logic [XLEN-1:0]  out_data,
  input logic             out_cond_we,
  input logic [CONDW-1:0] out_cond
);
  // Independent record of which edges accepted an operation.
  logic [DEPTH-1:0] acc_hist;

  always_ff @(posedge clk) begin
    if (rst) acc_hist <= '0;
    else     acc_hist <= {acc_hist[DEPTH-2:0], in_valid};
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == acc_hist[DEPTH-1]);

  p_we_match_r6: assert property (@(posedge clk) disable iff (rst)
    out_reg_we == out_valid);

  p_cond_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    out_cond_we |-> out_valid);

  p_cond_code_r8: assert property (@(posedge clk) disable iff (rst)
    out_cond_we |-> ($countones(out_cond[CONDW-1:CONDW-4]) == 1 &&
                     out_cond[CONDW-5:0] == '0));

  p_cond_sign_r8: assert property (@(posedge clk) disable iff (rst)
    out_cond_we |-> (out_cond[CONDW-1] == out_data[XLEN-1]));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind mul_unit mul_unit_chk #(.XLEN(XLEN), .DEPTH(DEPTH), .CONDW(CONDW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_reg_we (out_reg_we),
  .out_data   (out_data),
  .out_cond_we(out_cond_we),
  .out_cond   (out_cond)
);

// File: tb/mul_unit_tb.sv
module mul_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = '0;
  logic [4:0]  in_dst = '0;
  logic        in_rec = 1'b0;
  logic [64:0] in_a = '0;
  logic [64:0] in_b = '0;
  logic        out_valid, out_reg_we, out_cond_we;
  logic [4:0]  out_dst;
  logic [63:0] out_data;
  logic [31:0] out_cond;

  mul_unit #(.XLEN(64), .REGW(5), .DEPTH(DEPTH), .CONDW(32)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_rec(in_rec), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_reg_we(out_reg_we), .out_dst(out_dst),
    .out_data(out_data), .out_cond_we(out_cond_we), .out_cond(out_cond)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [4:0]  dst;
    logic [63:0] data;
    logic        cwe;
    logic [31:0] cond;
    string       tag;
  } item_t;

  item_t q[$];
  int nchk = 0;
  int nerr = 0;
  int nrecv = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] ref_res(input logic [1:0] op, input logic [64:0] a, input logic [64:0] b);
    logic signed [129:0] p;
    p = $signed({{65{a[64]}}, a}) * $signed({{65{b[64]}}, b});
    case (op)
      2'd1:    return p[127:64];
      2'd2:    return {p[63:32], p[63:32]};
      default: return p[63:0];
    endcase
  endfunction

  function automatic logic [31:0] ref_cond(input logic rec, input logic [63:0] r);
    if (!rec) return 32'h0;
    if (r[63]) return 32'h8000_0000;
    if (r == 64'h0) return 32'h2000_0000;
    return 32'h4000_0000;
  endfunction

  // Driver: presents one operation at a falling edge and records the expected
  // result. Issue stays continuous until idle() is called.
  task automatic drive(input logic [1:0] op, input logic [4:0] dst, input logic rec,
                       input logic [64:0] a, input logic [64:0] b, input string tag);
    item_t it;
    logic [63:0] r;
    r = ref_res(op, a, b);
    in_valid = 1'b1; in_op = op; in_dst = dst; in_rec = rec; in_a = a; in_b = b;
    it.due  = cyc + DEPTH;
    it.dst  = dst;
    it.data = r;
    it.cwe  = rec;
    it.cond = ref_cond(rec, r);
    it.tag  = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_a = '0; in_b = '0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares results at falling edges, well clear of the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        nrecv++;
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected out_valid", 64'(out_valid), 64'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(cyc == it.due, "R1 latency", 64'(cyc), 64'(it.due));
          chk(out_dst == it.dst, "R6 dst", 64'(out_dst), 64'(it.dst));
          chk(out_reg_we == 1'b1, "R6 reg_we", 64'(out_reg_we), 64'h1);
          chk(out_data == it.data, it.tag, out_data, it.data);
          chk(out_cond_we == it.cwe, it.cwe ? "R8 cond_we" : "R7 cond_we", 64'(out_cond_we), 64'(it.cwe));
          chk(out_cond == it.cond, it.cwe ? "R8 cond" : "R7 cond", 64'(out_cond), 64'(it.cond));
        end
      end else begin
        if (q.size() > 0 && q[0].due <= cyc)
          chk(1'b0, "R1 missing out_valid", 64'(out_valid), 64'h1);
        if (out_reg_we) chk(1'b0, "R6 reg_we without valid", 64'(out_reg_we), 64'h0);
      end
    end
  end

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [63:0] x, y;
    logic [15:0] si;
    int base;
    void'($urandom(32'd7));
    // R10: outputs cleared while held in reset
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 64'h0);
    chk(out_cond_we == 1'b0, "R10 reset cond_we", 64'(out_cond_we), 64'h0);
    rst = 1'b0;
    idle(2);
    // R2: idle gives no output
    for (int i = 0; i < 6; i++) begin
      chk(out_valid == 1'b0, "R2 idle", 64'(out_valid), 64'h0);
      @(negedge clk);
    end

    // R3: worked example, with and without record; R8 positive code
    drive(2'd0, 5'd17, 1'b0, 65'h1000, 65'h1111, "R3 example");
    idle(5);
    drive(2'd0, 5'd17, 1'b1, 65'h1000, 65'h1111, "R3 example rec");
    idle(5);
    // R8: zero and negative codes; R3: unused code 3 acts as low doubleword
    drive(2'd0, 5'd1, 1'b1, 65'h0, 65'h1234, "R8 zero");
    drive(2'd3, 5'd2, 1'b1, {65{1'b1}}, 65'h5, "R3 code3 negative");
    // R4: all-ones times two, unsigned vs signed high doubleword
    drive(2'd1, 5'd3, 1'b0, {1'b0, {64{1'b1}}}, 65'h2, "R4 unsigned high");
    drive(2'd1, 5'd4, 1'b1, {65{1'b1}}, 65'h2, "R4 signed high");
    // R5: high word of -1 * -1 (signed) vs 0xFFFFFFFF^2 (unsigned)
    drive(2'd2, 5'd5, 1'b1, {65{1'b1}}, {65{1'b1}}, "R5 signed high word");
    drive(2'd2, 5'd6, 1'b1, 65'hFFFF_FFFF, 65'hFFFF_FFFF, "R5 unsigned high word");
    idle(6);

    // R9: back-to-back burst of 8, in order, one each
    base = nrecv;
    for (int i = 0; i < 8; i++) begin
      drive(2'd0, 5'(i + 8), 1'b0, 65'(i + 1), 65'h3, "R9 burst");
    end
    idle(DEPTH + 3);
    chk(nrecv - base == 8, "R9 burst count", 64'(nrecv - base), 64'd8);

    // Random coverage of every widening form, issue gaps 0..2
    for (int i = 0; i < 250; i++) begin
      x = r64(); y = r64();
      drive(2'd0, 5'($urandom()), 1'($urandom()), {1'b0, x}, {1'b0, y}, "R3 low dword");
      if ($urandom() % 3 == 0) idle($urandom() % 3);
      x = r64(); y = r64();
      drive(2'd1, 5'($urandom()), 1'($urandom()), {1'b0, x}, {1'b0, y}, "R4 unsigned high");
      x = r64(); y = r64();
      drive(2'd1, 5'($urandom()), 1'($urandom()), {x[63], x}, {y[63], y}, "R4 signed high");
      if ($urandom() % 3 == 0) idle($urandom() % 3);
      x = r64(); y = r64();
      drive(2'd0, 5'($urandom()), 1'($urandom()), {{33{x[31]}}, x[31:0]}, {{33{y[31]}}, y[31:0]}, "R3 low word");
      x = r64(); y = r64();
      drive(2'd2, 5'($urandom()), 1'($urandom()), {{33{x[31]}}, x[31:0]}, {{33{y[31]}}, y[31:0]}, "R5 signed high word");
      x = r64(); y = r64();
      drive(2'd2, 5'($urandom()), 1'($urandom()), {33'h0, x[31:0]}, {33'h0, y[31:0]}, "R5 unsigned high word");
      x = r64(); si = 16'($urandom());
      drive(2'd0, 5'($urandom()), 1'($urandom()), {x[63], x}, {{49{si[15]}}, si}, "R3 immediate");
      if ($urandom() % 2 == 0) idle($urandom() % 3);
    end
    idle(DEPTH + 3);
    chk(q.size() == 0, "R9 all results returned", 64'(q.size()), 64'h0);

    // R10: reset with work in flight; nothing may emerge afterwards
    drive(2'd0, 5'd30, 1'b1, 65'h7, 65'h9, "R10 flight");
    drive(2'd0, 5'd31, 1'b1, 65'h8, 65'h9, "R10 flight");
    in_valid = 1'b0;
    rst = 1'b1;
    q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      chk(out_valid == 1'b0, "R10 flushed", 64'(out_valid), 64'h0);
      @(negedge clk);
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule